// File: doc/BRIEF.md
# Dual-Channel Wiper Register I2C Slave

This block is an I2C slave that holds two 8-bit wiper codes for a pair of digitally set resistor dividers. It runs from a fast system clock and watches SCL and SDA as ordinary inputs. It finds start and stop conditions, matches its own 7-bit address and then takes commands over the bus. The upper five bits of the address are fixed. The lowest two bits come from a pair of strap pins.

A write carries an instruction byte and may carry a data byte after it. The instruction byte does several things at once:
- it picks a channel and records it as a pointer;
- it can force the picked wiper to midscale;
- it sets or clears a shutdown flag;
- it loads two general-purpose output latches.

The data byte, when present, replaces the code of the picked wiper. A read returns the code of the channel named by the most recent write.

The block drives SDA only through a pull-down enable. The board supplies the open-drain wire.

Top module: `dual_wiper_i2c`

## Requirements
- R1: After reset, both wiper codes are 0x80, the shutdown flag and both output latches are 0, and SDA is released.
- R2: A start condition (SDA falling while SCL is high) begins an address byte. A stop condition (SDA rising while SCL is high) returns the slave to idle with SDA released. A start or stop inside a byte discards that partial byte and applies nothing from it.
- R3: Bytes are sent MSB first. The address byte is the 7-bit address followed by a read flag (1 = read). The address is binary 01011 followed by strap bit 1 and then strap bit 0. The slave acknowledges (holds SDA low during the ninth clock) only on a match. On a mismatch it leaves every later byte unacknowledged until the next start or stop.
- R4: In a write, the slave acknowledges both the instruction byte and the data byte.
- R5: Instruction bit 7 picks the channel (0 = wiper 1, 1 = wiper 2). The choice is kept as the pointer for later reads and data writes.
- R6: When instruction bit 6 is 1, the picked wiper is loaded with 0x80 on the ninth clock of the instruction byte.
- R7: Instruction bit 5 is copied to the shutdown flag by every instruction byte.
- R8: Instruction bit 4 drives output latch 1 and bit 3 drives output latch 2, and every instruction byte updates both. Bits 2 to 0 have no effect.
- R9: The data byte is written to the picked wiper on its ninth clock. A stop after the instruction byte, or a stop or start part-way through the data byte, leaves both wipers unchanged. The instruction controls of that write are still applied.
- R10: In a read, after the address is acknowledged, the slave sends the picked wiper MSB first. It changes SDA only while SCL is low and releases SDA after the eighth bit. A read changes no wiper, flag or latch.
- R11: Any byte after the data byte in the same write is not acknowledged and has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| scl_i | input | 1 | Bus clock line as seen on the wire |
| sda_i | input | 1 | Bus data line as seen on the wire |
| strap_i | input | 2 | Address strap levels, bit 1 above bit 0 |
| sda_pull_o | output | 1 | 1 pulls SDA low (acknowledge or read data zero) |
| wiper1_o | output | 8 | Code of wiper 1 |
| wiper2_o | output | 8 | Code of wiper 2 |
| shutdown_o | output | 1 | Shutdown flag, active high |
| out1_o | output | 1 | General-purpose output latch 1 |
| out2_o | output | 1 | General-purpose output latch 2 |

## Verification
The cases that are hardest to reach from the ports are transfers that end part-way through a frame. These are a stop right after the instruction acknowledge, and a start or stop after only a few bits of the instruction or data byte. In these cases the instruction controls must hold while the wiper stays untouched. A byte-level master cannot produce them, so the bench drives the bus one bit at a time. It sends a partial byte and then a start or stop condition. A behavioural model, updated on the master's ninth-clock edges, is compared with the outputs on every clock. Reads after each case show which pointer the slave kept.

// File: rtl/dual_wiper_i2c.sv
module dual_wiper_i2c #(
  parameter logic [4:0] ADDR_HI  = 5'b01011,
  parameter logic [7:0] MID_CODE = 8'h80
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  input  logic [1:0] strap_i,
  output logic       sda_pull_o,
  output logic [7:0] wiper1_o,
  output logic [7:0] wiper2_o,
  output logic       shutdown_o,
  output logic       out1_o,
  output logic       out2_o
);

  localparam logic [3:0] LAST_BIT = 4'd8;
  localparam logic [3:0] ACK_BIT  = 4'd9;

  typedef enum logic [2:0] {S_IDLE, S_ADDR, S_INSTR, S_DATA, S_READ, S_WAIT} st_t;

  st_t        st;
  logic [2:0] scl_q, sda_q;
  logic [3:0] cnt;
  logic [7:0] sreg, txsh;
  logic       ack, drv, sel;

  wire scl_s = scl_q[1];
  wire scl_p = scl_q[2];
  wire sda_s = sda_q[1];
  wire sda_p = sda_q[2];

  wire scl_rise = scl_s & ~scl_p;
  wire scl_fall = ~scl_s & scl_p;
  wire start_c  = scl_s & scl_p & sda_p & ~sda_s;
  wire stop_c   = scl_s & scl_p & ~sda_p & sda_s;
  wire addr_hit = (sreg[7:1] == {ADDR_HI, strap_i});
  wire rx_state = (st == S_ADDR) || (st == S_INSTR) || (st == S_DATA);
  wire [7:0] rd_word = sel ? wiper2_o : wiper1_o;

  assign sda_pull_o = ack | drv;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 3'b111;
      sda_q <= 3'b111;
    end else begin
      scl_q <= {scl_q[1:0], scl_i};
      sda_q <= {sda_q[1:0], sda_i};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st         <= S_IDLE;
      cnt        <= '0;
      sreg       <= '0;
      txsh       <= '0;
      ack        <= 1'b0;
      drv        <= 1'b0;
      sel        <= 1'b0;
      wiper1_o   <= MID_CODE;
      wiper2_o   <= MID_CODE;
      shutdown_o <= 1'b0;
      out1_o     <= 1'b0;
      out2_o     <= 1'b0;
    end else if (start_c) begin
      st  <= S_ADDR;
      cnt <= '0;
      ack <= 1'b0;
      drv <= 1'b0;
    end else if (stop_c) begin
      st  <= S_IDLE;
      cnt <= '0;
      ack <= 1'b0;
      drv <= 1'b0;
    end else if (rx_state) begin
      if (scl_rise && cnt < LAST_BIT) begin
        sreg <= {sreg[6:0], sda_s};
        cnt  <= cnt + 4'd1;
      end
      if (scl_fall && cnt == LAST_BIT) begin
        if (st != S_ADDR || addr_hit) begin
          ack <= 1'b1;
          cnt <= ACK_BIT;
        end else begin
          st <= S_WAIT;
        end
      end
      if (scl_rise && cnt == ACK_BIT) begin
        if (st == S_INSTR) begin
          sel        <= sreg[7];
          shutdown_o <= sreg[5];
          out1_o     <= sreg[4];
          out2_o     <= sreg[3];
          if (sreg[6] && sreg[7])  wiper2_o <= MID_CODE;
          if (sreg[6] && !sreg[7]) wiper1_o <= MID_CODE;
        end else if (st == S_DATA) begin
          if (sel) wiper2_o <= sreg;
          else     wiper1_o <= sreg;
        end
      end
      if (scl_fall && cnt == ACK_BIT) begin
        ack <= 1'b0;
        cnt <= '0;
        if (st == S_ADDR && sreg[0]) begin
          st   <= S_READ;
          txsh <= rd_word;
          drv  <= ~rd_word[7];
        end else if (st == S_ADDR) begin
          st <= S_INSTR;
        end else if (st == S_INSTR) begin
          st <= S_DATA;
        end else begin
          st <= S_WAIT;
        end
      end
    end else if (st == S_READ && scl_fall) begin
      if (cnt == 4'd7) begin
        drv <= 1'b0;
        cnt <= '0;
        st  <= S_WAIT;
      end else begin
        cnt  <= cnt + 4'd1;
        txsh <= {txsh[6:0], 1'b0};
        drv  <= ~txsh[6];
      end
    end
  end

  p_idle_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IDLE) |-> !sda_pull_o);

  p_stop_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_c && !start_c) |=> (st == S_IDLE && !sda_pull_o));

  p_ack_match_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_ADDR && sda_pull_o) |-> addr_hit);

  p_shd_instr_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(shutdown_o) |-> ($past(st) == S_INSTR));

  p_out_instr_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(out1_o) || !$stable(out2_o)) |-> ($past(st) == S_INSTR));

  p_wiper_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(wiper1_o) || !$stable(wiper2_o)) |-> ($past(st) == S_INSTR || $past(st) == S_DATA));

  p_read_still_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_READ) |=> ($stable(wiper1_o) && $stable(wiper2_o) && $stable(shutdown_o)));

  p_read_scl_low_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_READ && $changed(drv)) |-> !scl_s);

endmodule

// File: tb/dual_wiper_i2c_test.sv
module dual_wiper_i2c_test;
  localparam int Q = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl = 1'b1;
  logic m_sda = 1'b1;
  logic [1:0] strap = 2'b01;
  logic sda_pull, shd, o1, o2;
  logic [7:0] w1, w2;
  wire sda_bus = m_sda & ~sda_pull;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;
  int last_upd = 0;
  bit done = 1'b0;

  logic [7:0] exp_w [2];
  logic exp_ptr, exp_sd, exp_o1, exp_o2;

  dual_wiper_i2c uut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_bus), .strap_i(strap),
    .sda_pull_o(sda_pull), .wiper1_o(w1), .wiper2_o(w2),
    .shutdown_o(shd), .out1_o(o1), .out2_o(o2));

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // per-clock comparison of outputs with the behavioural model (R9 and controls)
  always @(negedge clk) begin
    if (rst_n && !done && (cyc - last_upd) > 8)
      chk("R9 model compare", {w1, w2, shd, o1, o2},
          {exp_w[0], exp_w[1], exp_sd, exp_o1, exp_o2});
  end

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [6:0] my_addr();
    return {5'b01011, strap};
  endfunction

  task automatic model_apply(int kind, logic [7:0] v);
    if (kind == 1) begin
      exp_ptr = v[7];
      if (v[6]) exp_w[v[7]] = 8'h80;
      exp_sd = v[5];
      exp_o1 = v[4];
      exp_o2 = v[3];
    end else if (kind == 2) begin
      exp_w[exp_ptr] = v;
    end
    last_upd = cyc;
  endtask

  task automatic bus_start();
    m_sda = 1'b1; tick(Q);
    scl = 1'b1;   tick(Q);
    m_sda = 1'b0; tick(Q);
    scl = 1'b0;   tick(2);
  endtask

  task automatic bus_stop();
    m_sda = 1'b0; tick(Q);
    scl = 1'b1;   tick(Q);
    m_sda = 1'b1; tick(Q);
  endtask

  task automatic put_bit(bit b);
    m_sda = b; tick(Q);
    scl = 1'b1; tick(Q);
    scl = 1'b0; tick(2);
  endtask

  task automatic put_byte(logic [7:0] v, bit exp_ack, int kind, string tag);
    for (int i = 7; i >= 0; i--) put_bit(v[i]);
    m_sda = 1'b1; tick(Q);
    scl = 1'b1;
    if (exp_ack) model_apply(kind, v);
    tick(Q/2);
    chk(tag, !sda_bus, exp_ack);
    tick(Q - Q/2);
    scl = 1'b0; tick(2);
  endtask

  task automatic write_txn(logic [6:0] a, logic [7:0] ins, bit with_data, logic [7:0] d);
    bit ok;
    ok = (a == my_addr());
    bus_start();
    put_byte({a, 1'b0}, ok, 0, "R3 address ack");
    put_byte(ins, ok, 1, "R4 instruction ack");
    if (with_data) put_byte(d, ok, 2, "R4 data ack");
    bus_stop();
  endtask

  task automatic read_txn(string tag);
    logic [7:0] v;
    bus_start();
    put_byte({my_addr(), 1'b1}, 1'b1, 0, "R3 read address ack");
    for (int i = 7; i >= 0; i--) begin
      m_sda = 1'b1; tick(Q);
      scl = 1'b1; tick(Q/2);
      v[i] = sda_bus;
      tick(Q - Q/2);
      scl = 1'b0; tick(2);
    end
    put_bit(1'b1);
    chk(tag, v, exp_w[exp_ptr]);
    bus_stop();
    chk("R10 SDA released after read", sda_pull, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    exp_w[0] = 8'h80; exp_w[1] = 8'h80;
    exp_ptr = 1'b0; exp_sd = 1'b0; exp_o1 = 1'b0; exp_o2 = 1'b0;
    tick(5);
    rst_n = 1'b1;
    tick(3);
    chk("R1 reset wipers", {w1, w2}, 16'h8080);
    chk("R1 reset flags", {shd, o1, o2}, 0);
    chk("R1 reset SDA", sda_pull, 0);

    write_txn(my_addr(), 8'h18, 1'b1, 8'h3C);
    tick(12);
    chk("R9 wiper1 written", w1, 8'h3C);
    chk("R8 outputs set", {o1, o2}, 2'b11);
    read_txn("R10 read wiper1");

    write_txn(my_addr(), 8'hA0, 1'b1, 8'hA5);
    tick(12);
    chk("R7 shutdown set", shd, 1);
    chk("R8 outputs cleared", {o1, o2}, 2'b00);
    read_txn("R5 pointer to wiper2");

    write_txn(my_addr(), 8'hC0, 1'b0, 8'h00);
    tick(12);
    chk("R6 midscale wiper2", w2, 8'h80);
    chk("R7 shutdown cleared", shd, 0);
    chk("R6 wiper1 untouched", w1, 8'h3C);

    write_txn(my_addr(), 8'h07, 1'b1, 8'h01);
    tick(12);
    chk("R8 low bits ignored", {o1, o2}, 2'b00);
    read_txn("R10 read wiper1 mostly zero");

    write_txn({5'b01011, ~strap}, 8'hFF, 1'b1, 8'h55);
    tick(12);
    chk("R3 mismatch leaves wipers", {w1, w2}, 16'h0180);
    chk("R3 mismatch leaves flags", {shd, o1, o2}, 0);
    write_txn(7'h2C ^ 7'h10, 8'hFF, 1'b0, 8'h00);

    bus_start();
    put_byte({my_addr(), 1'b0}, 1'b1, 0, "R3 address ack");
    put_byte(8'h10, 1'b1, 1, "R4 instruction ack");
    put_bit(1'b1); put_bit(1'b1); put_bit(1'b1); put_bit(1'b1);
    bus_stop();
    tick(12);
    chk("R9 partial data dropped", w1, 8'h01);
    chk("R9 instruction kept", o1, 1);

    bus_start();
    put_byte({my_addr(), 1'b0}, 1'b1, 0, "R3 address ack");
    put_bit(1'b1); put_bit(1'b1); put_bit(1'b1); put_bit(1'b1); put_bit(1'b1);
    bus_start();
    put_byte({my_addr(), 1'b0}, 1'b1, 0, "R2 address after restart");
    put_byte(8'h80, 1'b1, 1, "R2 instruction after restart");
    put_byte(8'h11, 1'b1, 2, "R2 data after restart");
    bus_stop();
    tick(12);
    chk("R2 restart write", w2, 8'h11);
    chk("R2 aborted instruction dropped", {shd, o1, o2}, 0);

    bus_start();
    put_byte({my_addr(), 1'b0}, 1'b1, 0, "R3 address ack");
    put_byte(8'h00, 1'b1, 1, "R4 instruction ack");
    put_byte(8'h42, 1'b1, 2, "R4 data ack");
    put_byte(8'h99, 1'b0, 0, "R11 extra byte not acked");
    bus_stop();
    tick(12);
    chk("R11 extra byte no effect", w1, 8'h42);

    strap = 2'b10;
    tick(4);
    write_txn(my_addr(), 8'h88, 1'b1, 8'hF0);
    tick(12);
    chk("R3 new strap match", w2, 8'hF0);
    read_txn("R10 read after strap change");
    chk("R2 idle SDA released", sda_pull, 0);

    tick(20);
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule